// File: doc/BRIEF.md
# Multi-Cycle Unsigned Restoring Divider

This block divides an unsigned N-bit dividend by an unsigned N-bit divisor over several clock cycles. It produces an N-bit quotient and an N-bit remainder. A single working register holds both results. Its upper part carries the partial remainder, and quotient bits are shifted in at its low end one per step.

The dividend is loaded already shifted left by one place. Each step then trial-subtracts the captured divisor from the upper part. A negative trial keeps the old upper part, which is the restore; a non-negative trial keeps the difference. The register then moves left by one with the new quotient bit entering at bit 0. After N steps, a commit cycle takes the quotient from the low half and the remainder from the upper part moved right by one place.

A caller raises `start` for one cycle while the block is idle. It then waits for the one-cycle `done` pulse and reads the outputs, which stay put until the next result is written. A zero divisor is not run through the loop: it finishes at once and raises a flag.

Top module: `restoring_divider`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `done` and `divByZero` are 0, and `quotient` and `remainder` are 0.
- R2: A `start` seen at a clock edge while `busy` is 0 and `divisor` is non-zero is accepted. `busy` is then 1 for exactly WIDTH+1 cycles, starting in the cycle after that edge.
- R3: `done` is 1 for exactly one cycle. That cycle is the first one in which `busy` has returned to 0, or the cycle after an accepted start with a zero divisor. `busy` is never 1 while `done` is 1.
- R4: On completion with a non-zero divisor, `quotient` equals floor(dividend / divisor) and `remainder` equals dividend mod divisor, so `remainder` is below `divisor`. For WIDTH=8, 73 / 5 gives quotient 14 and remainder 3.
- R5: The dividend and divisor are captured at the accepted start. Changes on those inputs while `busy` is 1 do not affect the result.
- R6: A `start` seen while `busy` is 1 is ignored: the run in progress keeps its length and its result.
- R7: An accepted start with `divisor` equal to 0 does not raise `busy`. In the next cycle, `done` and `divByZero` are 1, `quotient` is all ones and `remainder` equals the dividend.
- R8: `divByZero` stays 1 until the next completion with a non-zero divisor, which clears it to 0.
- R9: In every cycle without `done`, `quotient`, `remainder` and `divByZero` keep their previous values.
- R10: Edge operands give exact results: dividend below divisor gives quotient 0 and remainder equal to the dividend; divisor 1 gives quotient equal to the dividend and remainder 0; all-ones by all-ones gives 1 and 0.
- R11: A `start` raised in the same cycle as `done` is accepted, so runs can follow one another with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a division; taken only while idle |
| dividend | input | WIDTH | Unsigned dividend |
| divisor | input | WIDTH | Unsigned divisor |
| busy | output | 1 | A division is in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | WIDTH | Result quotient, held between completions |
| remainder | output | WIDTH | Result remainder, held between completions |
| divByZero | output | 1 | Last completed request had a zero divisor |

## Verification
The collision that matters is a new request landing in the same cycle as a completion. The commit of one result and the load of the next operands then happen at a single edge. The bench provokes it by raising `start` in the `done` cycle, and also by raising `start` while the last step is being taken. A cycle-by-cycle model judges both: it expects the first case to begin a new run at once with the finished result intact, and the second case to be dropped.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } rdivState_t;

  // Strobes handed from the sequencer to the datapath.
  typedef struct packed {
    logic load;        // capture operands, pre-shifted
    logic step;        // one trial-subtract / shift step
    logic commit;      // realign and publish the result
    logic commitZero;  // publish the zero-divisor result
  } rdivStrobe_t;

endpackage

// File: rtl/rdiv_ctrl.sv
module rdiv_ctrl
  import rdiv_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        divisorZero,
  output rdivStrobe_t strobe,
  output logic        busy,
  output logic        done
);

  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] LAST_STEP = CW'(WIDTH - 1);

  rdivState_t state;
  logic [CW-1:0] stepCnt;
  logic accept;

  assign accept = (state == ST_IDLE) && start;
  assign busy   = (state != ST_IDLE);

  always_comb begin
    strobe            = '0;
    strobe.load       = accept && !divisorZero;
    strobe.commitZero = accept && divisorZero;
    strobe.step       = (state == ST_RUN);
    strobe.commit     = (state == ST_FIX);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= strobe.commit || strobe.commitZero;
      case (state)
        ST_IDLE: begin
          if (strobe.load) begin
            state   <= ST_RUN;
            stepCnt <= '0;
          end
        end
        ST_RUN: begin
          stepCnt <= stepCnt + 1'b1;
          if (stepCnt == LAST_STEP) state <= ST_FIX;
        end
        ST_FIX:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rdiv_datapath.sv
module rdiv_datapath
  import rdiv_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  rdivStrobe_t      strobe,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder,
  output logic             divByZero
);

  // One extra bit above the two halves keeps the shifted partial
  // remainder whole before it is compared.
  localparam int RW = 2 * WIDTH + 1;
  localparam int TW = WIDTH + 2;

  logic [RW-1:0]    work;
  logic [WIDTH-1:0] divReg;
  logic [WIDTH:0]   upperPart;
  logic [TW-1:0]    trial;
  logic             trialNeg;
  logic [WIDTH:0]   keptUpper;
  logic [RW-1:0]    workNext;

  assign upperPart = work[RW-1:WIDTH];
  assign trial     = {1'b0, upperPart} - {2'b00, divReg};
  assign trialNeg  = trial[TW-1];
  // Restore is a select: a negative trial leaves the upper part untouched.
  assign keptUpper = trialNeg ? upperPart : trial[WIDTH:0];
  assign workNext  = {keptUpper[WIDTH-1:0], work[WIDTH-1:0], ~trialNeg};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      work   <= '0;
      divReg <= '0;
    end else if (strobe.load) begin
      work   <= {{WIDTH{1'b0}}, dividend, 1'b0};
      divReg <= divisor;
    end else if (strobe.step) begin
      work <= workNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      quotient  <= '0;
      remainder <= '0;
      divByZero <= 1'b0;
    end else if (strobe.commit) begin
      quotient  <= work[WIDTH-1:0];
      remainder <= work[RW-1:WIDTH+1];
      divByZero <= 1'b0;
    end else if (strobe.commitZero) begin
      quotient  <= '1;
      remainder <= dividend;
      divByZero <= 1'b1;
    end
  end

endmodule

// File: rtl/restoring_divider.sv
module restoring_divider
  import rdiv_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder,
  output logic             divByZero
);

  rdivStrobe_t strobe;
  logic divisorZero;

  assign divisorZero = (divisor == '0);

  rdiv_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .divisorZero (divisorZero),
    .strobe      (strobe),
    .busy        (busy),
    .done        (done)
  );

  rdiv_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .dividend  (dividend),
    .divisor   (divisor),
    .quotient  (quotient),
    .remainder (remainder),
    .divByZero (divByZero)
  );

endmodule

// File: rtl/rdiv_checker.sv
module rdiv_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [WIDTH-1:0] dividend,
  input logic [WIDTH-1:0] divisor,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] quotient,
  input logic [WIDTH-1:0] remainder,
  input logic             divByZero
);

  localparam int PW = 2 * WIDTH;

  logic [WIDTH-1:0] capDividend;
  logic [WIDTH-1:0] capDivisor;
  logic [PW-1:0]    rebuilt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capDividend <= '0;
      capDivisor  <= '0;
    end else if (start && !busy) begin
      capDividend <= dividend;
      capDivisor  <= divisor;
    end
  end

  assign rebuilt = PW'(quotient) * PW'(capDivisor) + PW'(remainder);

  assert_start_raises_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && divisor != '0) |=> busy);

  assert_busy_ends_in_done_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_not_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  assert_result_exact_R4: assert property (@(posedge clk) disable iff (!rstN)
    (done && !divByZero) |-> (rebuilt == PW'(capDividend) && remainder < capDivisor));

  assert_zero_divisor_R7: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && divisor == '0) |=>
      (done && divByZero && !busy && quotient == '1 && remainder == $past(dividend)));

  assert_outputs_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(quotient) && $stable(remainder) && $stable(divByZero)));

endmodule

bind restoring_divider rdiv_checker #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .dividend  (dividend),
  .divisor   (divisor),
  .busy      (busy),
  .done      (done),
  .quotient  (quotient),
  .remainder (remainder),
  .divByZero (divByZero)
);

// File: tb/tb_restoring_divider.sv
module tb_restoring_divider;

  localparam int W = 8;
  localparam int LIMIT = 200000;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic         busy, done, divByZero;
  logic [W-1:0] quotient, remainder;

  int vectors = 0;
  int misses = 0;
  int cycles = 0;
  bit finished = 0;

  restoring_divider #(.WIDTH(W)) dut (
    .clk(clk), .rstN(rstN), .start(start), .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .quotient(quotient), .remainder(remainder),
    .divByZero(divByZero)
  );

  always #5 clk = ~clk;

  // Behavioural reference: a countdown and a pending result.
  bit           mBusy = 0, mDone = 0, mZero = 0;
  int           mCnt = 0;
  logic [W-1:0] mQ = '0, mR = '0, pendQ = '0, pendR = '0;

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mDone = 0; mZero = 0; mCnt = 0; mQ = '0; mR = '0;
    end else begin
      mDone = 0;
      if (mBusy) begin
        mCnt = mCnt - 1;
        if (mCnt == 0) begin
          mBusy = 0; mDone = 1; mQ = pendQ; mR = pendR; mZero = 0;
        end
      end else if (start) begin
        if (divisor == 0) begin
          mDone = 1; mZero = 1; mQ = '1; mR = dividend;
        end else begin
          mBusy = 1; mCnt = W + 1;
          pendQ = dividend / divisor; pendR = dividend % divisor;
        end
      end
    end
  end

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !finished) begin
      check("R2 busy", W'(busy), W'(mBusy));
      check("R3 done", W'(done), W'(mDone));
      check("R4 quotient", quotient, mQ);
      check("R4 remainder", remainder, mR);
      check("R7 divByZero", W'(divByZero), W'(mZero));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > LIMIT && !finished) begin
      misses++;
      vectors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, LIMIT);
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  // Issue one request and return at the negedge of its done cycle.
  task automatic runOp(logic [W-1:0] a, logic [W-1:0] b);
    @(negedge clk); #1;
    start = 1; dividend = a; divisor = b;
    @(negedge clk);
    start = 0;
    while (done !== 1'b1) @(negedge clk);
  endtask

  task automatic expectResult(string tag, logic [W-1:0] q, logic [W-1:0] r, logic z);
    check({tag, " quotient"}, quotient, q);
    check({tag, " remainder"}, remainder, r);
    check({tag, " flag"}, W'(divByZero), W'(z));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: values under reset
    check("R1 busy", W'(busy), '0);
    check("R1 done", W'(done), '0);
    check("R1 quotient", quotient, '0);
    check("R1 remainder", remainder, '0);
    check("R1 flag", W'(divByZero), '0);
    rstN = 1;

    runOp(8'd73, 8'd5);   expectResult("R4 73/5", 8'd14, 8'd3, 0);
    runOp(8'd100, 8'd7);  expectResult("R4 100/7", 8'd14, 8'd2, 0);
    runOp(8'd255, 8'd255); expectResult("R10 max/max", 8'd1, 8'd0, 0);
    runOp(8'd255, 8'd1);  expectResult("R10 max/1", 8'd255, 8'd0, 0);
    runOp(8'd3, 8'd200);  expectResult("R10 small/large", 8'd0, 8'd3, 0);
    runOp(8'd0, 8'd9);    expectResult("R10 zero dividend", 8'd0, 8'd0, 0);
    runOp(8'd128, 8'd2);  expectResult("R4 128/2", 8'd64, 8'd0, 0);

    // R7: zero divisor completes at once
    runOp(8'd77, 8'd0);
    expectResult("R7 zero", 8'hFF, 8'd77, 1);
    check("R7 busy", W'(busy), '0);
    // R9: outputs hold afterwards
    repeat (4) @(negedge clk);
    expectResult("R9 hold", 8'hFF, 8'd77, 1);
    // R8: next good run clears flag
    runOp(8'd20, 8'd3);   expectResult("R8 cleared", 8'd6, 8'd2, 0);

    // R5 and R6: operand change and extra start mid-run
    @(negedge clk); #1;
    start = 1; dividend = 8'd200; divisor = 8'd9;
    @(negedge clk); #1;
    start = 0; dividend = 8'd1; divisor = 8'd1;
    repeat (3) @(negedge clk);
    #1 start = 1; dividend = 8'd50; divisor = 8'd0;
    @(negedge clk); #1 start = 0;
    while (done !== 1'b1) @(negedge clk);
    expectResult("R5 R6 mid-run", 8'd22, 8'd2, 0);

    // start during final step is dropped (R6)
    @(negedge clk); #1;
    start = 1; dividend = 8'd90; divisor = 8'd4;
    @(negedge clk); #1 start = 0;
    repeat (W - 1) @(negedge clk);
    #1 start = 1; dividend = 8'd9; divisor = 8'd9;
    @(negedge clk);
    start = 0;
    while (done !== 1'b1) @(negedge clk);
    expectResult("R6 last step", 8'd22, 8'd2, 0);
    @(negedge clk);
    check("R6 no extra run", W'(busy), '0);

    // R11: start in the done cycle
    runOp(8'd61, 8'd6);
    #1 start = 1; dividend = 8'd250; divisor = 8'd11;
    @(negedge clk);
    start = 0;
    check("R11 busy", W'(busy), 8'd1);
    expectResult("R11 first held", 8'd10, 8'd1, 0);
    while (done !== 1'b1) @(negedge clk);
    expectResult("R11 second", 8'd22, 8'd8, 0);

    // R4 sweep
    for (int i = 0; i < 60; i++) begin
      logic [W-1:0] a, b;
      a = W'($urandom_range(0, 255));
      b = W'($urandom_range(1, 255));
      runOp(a, b);
      expectResult("R4 sweep", a / b, a % b, 0);
    end

    repeat (3) @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule